// File: doc/BRIEF.md
# Add/Subtract Execution Unit with Carry

This block is the integer add/subtract stage of a 32-bit processor pipeline. Each cycle in which `valid` is high it takes a first operand, a second operand and a selected operation, and registers the result. The five operations are plain add, add including an incoming carry, plain subtract, subtract including an incoming carry, and reverse subtract. The incoming carry acts as an inverted borrow for the subtract variants. For add and subtract only, the second operand may instead come from a 12-bit unsigned immediate. When the first operand is the program counter, its two low bits are cleared before the arithmetic, so the base is word-aligned.

The negative, zero, carry and overflow flags are produced from the same sum and are registered together with a one-cycle write-enable pulse. They change only when the issuing instruction asks for a flag update. Barrel shifting of the second operand, register file access and instruction decode belong to neighbouring blocks.

Top module: `addsub_unit`

## Requirements
- R1: With op code 0 (add) and a valid strobe, `result` equals opA + opB modulo 2^32 one clock after the strobe edge.
- R2: With op code 1 (add with carry), `result` equals opA + opB + carryIn.
- R3: With op code 2 (subtract), `result` equals opA - opB.
- R4: With op code 3 (subtract with carry), `result` equals opA - opB when carryIn is 1, and opA - opB - 1 when carryIn is 0.
- R5: With op code 4 (reverse subtract), `result` equals opB - opA.
- R6: When `useImm` is 1 and the op code is 0 or 2, the second operand is `imm12` zero-extended to 32 bits and `opB` is ignored. For op codes 1, 3 and 4, `useImm` has no effect and `opB` is used.
- R7: When `aIsPc` is 1, bits [1:0] of opA are taken as 00 before the arithmetic.
- R8: On a flag update, `flagN` equals result bit 31 and `flagZ` is 1 exactly when the result is zero. `flagC` is the adder carry-out, computed with subtract as A + ~B + 1 and subtract-with-carry as A + ~B + carryIn, so a 1 means no borrow. `flagV` is 1 when both adder inputs share a sign that differs from the result's sign.
- R9: Flags are written, and `flagWe` pulses high for one cycle, only after a valid strobe with `setFlags` = 1 and a legal op code. Otherwise the flags keep their values and `flagWe` is 0.
- R10: When `valid` is 0, or the op code is 5, 6 or 7, `result` and the flags hold.
- R11: A synchronous active-high `rst` clears `result`, all four flags and `flagWe` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Issue strobe for this cycle's operation |
| opSel | input | 3 | Operation code (0 add, 1 add+carry, 2 sub, 3 sub+carry, 4 reverse sub) |
| opA | input | 32 | First operand |
| opB | input | 32 | Register-derived second operand |
| imm12 | input | 12 | Unsigned immediate second operand |
| useImm | input | 1 | Select immediate as second operand (add/sub only) |
| carryIn | input | 1 | Incoming carry flag |
| setFlags | input | 1 | Flag-update request |
| aIsPc | input | 1 | First operand is the program counter |
| result | output | 32 | Registered result |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry / no-borrow flag |
| flagV | output | 1 | Signed overflow flag |
| flagWe | output | 1 | Flag write-enable pulse |

## Verification
The bench builds the unit with its default widths: a 32-bit datapath and a 12-bit immediate. With these widths the signed boundary between 0x7FFFFFFF and 0x80000000, and the all-ones wrap to zero, can be driven directly, so overflow and carry-out are both exercised. The largest immediate, 0xFFF, is also driven to confirm zero extension with no sign fill. A table of operations with hand-computed results and NZCV values covers every op code on both sides of each carry/borrow boundary. Directed steps then cover reset, flag hold without `setFlags`, an idle `valid`, the unused op codes, and immediates offered to operations that must ignore them.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_RSB = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_e;

  // strobes from control to datapath
  typedef struct packed {
    logic invA;
    logic invB;
    cin_e cinSel;
    logic immEn;
    logic loadRes;
    logic loadFlags;
  } ctrl_t;

endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
(
  input  logic [2:0] opSel,
  input  logic       valid,
  input  logic       useImm,
  input  logic       setFlags,
  output ctrl_t      ctrl
);

  logic legalOp;

  always_comb begin
    ctrl     = '0;
    legalOp  = 1'b1;
    case (opSel)
      OP_ADD: begin
        ctrl.cinSel = CIN_ZERO;
        ctrl.immEn  = useImm;
      end
      OP_ADC: begin
        ctrl.cinSel = CIN_FLAG;
      end
      OP_SUB: begin
        ctrl.invB   = 1'b1;
        ctrl.cinSel = CIN_ONE;
        ctrl.immEn  = useImm;
      end
      OP_SBC: begin
        ctrl.invB   = 1'b1;
        ctrl.cinSel = CIN_FLAG;
      end
      OP_RSB: begin
        ctrl.invA   = 1'b1;
        ctrl.cinSel = CIN_ONE;
      end
      default: begin
        legalOp = 1'b0;
      end
    endcase
    ctrl.loadRes   = valid && legalOp;
    ctrl.loadFlags = valid && legalOp && setFlags;
  end

endmodule

// File: rtl/addsub_adder.sv
module addsub_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] wide;

  always_comb begin
    wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
    sum  = wide[MSB:0];
    cout = wide[WIDTH];
    ovf  = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
  end

endmodule

// File: rtl/addsub_dp.sv
module addsub_dp
  import addsub_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int IMM_W       = 12,
  parameter int ALIGN_BITS  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [IMM_W-1:0] imm,
  input  logic             carryIn,
  input  logic             aIsPc,
  output logic [WIDTH-1:0] result,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagC,
  output logic             flagV,
  output logic             flagWe
);

  localparam int PAD = WIDTH - IMM_W;

  logic [WIDTH-1:0] baseA;
  logic [WIDTH-1:0] immWide;
  logic [WIDTH-1:0] opndB;
  logic [WIDTH-1:0] adderX;
  logic [WIDTH-1:0] adderY;
  logic             adderCin;
  logic [WIDTH-1:0] sum;
  logic             cout;
  logic             ovf;

  generate
    if (PAD > 0) begin : g_immPad
      assign immWide = {{PAD{1'b0}}, imm};
    end else begin : g_immFull
      assign immWide = imm[WIDTH-1:0];
    end
  endgenerate

  always_comb begin
    baseA = aIsPc ? {opA[WIDTH-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}} : opA;
    opndB = ctrl.immEn ? immWide : opB;
    adderX = ctrl.invA ? ~baseA : baseA;
    adderY = ctrl.invB ? ~opndB : opndB;
    case (ctrl.cinSel)
      CIN_ONE:  adderCin = 1'b1;
      CIN_FLAG: adderCin = carryIn;
      default:  adderCin = 1'b0;
    endcase
  end

  addsub_adder #(.WIDTH(WIDTH)) i_adder (
    .x   (adderX),
    .y   (adderY),
    .cin (adderCin),
    .sum (sum),
    .cout(cout),
    .ovf (ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      flagN  <= 1'b0;
      flagZ  <= 1'b0;
      flagC  <= 1'b0;
      flagV  <= 1'b0;
      flagWe <= 1'b0;
    end else begin
      flagWe <= ctrl.loadFlags;
      if (ctrl.loadRes) begin
        result <= sum;
      end
      if (ctrl.loadFlags) begin
        flagN <= sum[WIDTH-1];
        flagZ <= (sum == '0);
        flagC <= cout;
        flagV <= ovf;
      end
    end
  end

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [2:0]       opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [IMM_W-1:0] imm12,
  input  logic             useImm,
  input  logic             carryIn,
  input  logic             setFlags,
  input  logic             aIsPc,
  output logic [WIDTH-1:0] result,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagC,
  output logic             flagV,
  output logic             flagWe
);

  ctrl_t ctrl;

  addsub_ctrl i_ctrl (
    .opSel   (opSel),
    .valid   (valid),
    .useImm  (useImm),
    .setFlags(setFlags),
    .ctrl    (ctrl)
  );

  addsub_dp #(.WIDTH(WIDTH), .IMM_W(IMM_W), .ALIGN_BITS(2)) i_dp (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .opA    (opA),
    .opB    (opB),
    .imm    (imm12),
    .carryIn(carryIn),
    .aIsPc  (aIsPc),
    .result (result),
    .flagN  (flagN),
    .flagZ  (flagZ),
    .flagC  (flagC),
    .flagV  (flagV),
    .flagWe (flagWe)
  );

endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             valid,
  input logic [2:0]       opSel,
  input logic             setFlags,
  input logic [WIDTH-1:0] result,
  input logic             flagN,
  input logic             flagZ,
  input logic             flagC,
  input logic             flagV,
  input logic             flagWe
);

  logic legal;
  assign legal = (opSel <= 3'd4);

  // R8
  n_bit_chk: assert property (@(posedge clk) disable iff (rst)
    flagWe |-> (flagN == result[WIDTH-1]));

  // R8
  z_bit_chk: assert property (@(posedge clk) disable iff (rst)
    flagWe |-> (flagZ == (result == '0)));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(valid && setFlags) |=> $stable({flagN, flagZ, flagC, flagV}));

  // R9
  flag_we_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && setFlags && legal) |=> flagWe);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid || !legal) |=> $stable(result));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (result == '0 && !flagN && !flagZ && !flagC && !flagV && !flagWe));

endmodule

bind addsub_unit addsub_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .valid   (valid),
  .opSel   (opSel),
  .setFlags(setFlags),
  .result  (result),
  .flagN   (flagN),
  .flagZ   (flagZ),
  .flagC   (flagC),
  .flagV   (flagV),
  .flagWe  (flagWe)
);

// File: tb/test_addsub_unit.sv
`timescale 1ns/1ps
module test_addsub_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        valid;
  logic [2:0]  opSel;
  logic [31:0] opA, opB;
  logic [11:0] imm12;
  logic        useImm, carryIn, setFlags, aIsPc;
  logic [31:0] result;
  logic        flagN, flagZ, flagC, flagV, flagWe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  addsub_unit i_addsub_unit (
    .clk(clk), .rst(rst), .valid(valid), .opSel(opSel), .opA(opA), .opB(opB),
    .imm12(imm12), .useImm(useImm), .carryIn(carryIn), .setFlags(setFlags),
    .aIsPc(aIsPc), .result(result), .flagN(flagN), .flagZ(flagZ),
    .flagC(flagC), .flagV(flagV), .flagWe(flagWe)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [11:0] imm;
    logic        ui;
    logic        ci;
    logic        pc;
    logic [31:0] expRes;
    logic [3:0]  expNzcv;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'd5,          32'd3,          12'd0,     1'b0, 1'b0, 1'b0, 32'd8,          4'b0000}, // R1
    '{3'd0, 32'hFFFFFFFF,   32'd1,          12'd0,     1'b0, 1'b0, 1'b0, 32'd0,          4'b0110}, // R1 wrap
    '{3'd0, 32'h7FFFFFFF,   32'd1,          12'd0,     1'b0, 1'b0, 1'b0, 32'h80000000,   4'b1001}, // R1 ovf
    '{3'd2, 32'd5,          32'd3,          12'd0,     1'b0, 1'b0, 1'b0, 32'd2,          4'b0010}, // R3
    '{3'd2, 32'd3,          32'd5,          12'd0,     1'b0, 1'b0, 1'b0, 32'hFFFFFFFE,   4'b1000}, // R3 borrow
    '{3'd2, 32'h80000000,   32'd1,          12'd0,     1'b0, 1'b0, 1'b0, 32'h7FFFFFFF,   4'b0011}, // R3 ovf
    '{3'd1, 32'd1,          32'd2,          12'd0,     1'b0, 1'b1, 1'b0, 32'd4,          4'b0000}, // R2
    '{3'd1, 32'd1,          32'd2,          12'd0,     1'b0, 1'b0, 1'b0, 32'd3,          4'b0000}, // R2
    '{3'd3, 32'd10,         32'd4,          12'd0,     1'b0, 1'b1, 1'b0, 32'd6,          4'b0010}, // R4
    '{3'd3, 32'd10,         32'd4,          12'd0,     1'b0, 1'b0, 1'b0, 32'd5,          4'b0010}, // R4
    '{3'd4, 32'd3,          32'd10,         12'd0,     1'b0, 1'b0, 1'b0, 32'd7,          4'b0010}, // R5
    '{3'd4, 32'd10,         32'd3,          12'd0,     1'b0, 1'b0, 1'b0, 32'hFFFFFFF9,   4'b1000}, // R5
    '{3'd0, 32'h00000100,   32'h0000DEAD,   12'hFFF,   1'b1, 1'b0, 1'b0, 32'h000010FF,   4'b0000}, // R6
    '{3'd2, 32'h00001000,   32'h0000DEAD,   12'h001,   1'b1, 1'b0, 1'b0, 32'h00000FFF,   4'b0010}, // R6
    '{3'd1, 32'd1,          32'd7,          12'hFFF,   1'b1, 1'b0, 1'b0, 32'd8,          4'b0000}, // R6 ignored
    '{3'd0, 32'h00001003,   32'd4,          12'd0,     1'b0, 1'b0, 1'b1, 32'h00001004,   4'b0000}, // R7
    '{3'd2, 32'h00002002,   32'd0,          12'd2,     1'b1, 1'b0, 1'b1, 32'h00001FFE,   4'b0010}, // R7
    '{3'd2, 32'd7,          32'd7,          12'd0,     1'b0, 1'b0, 1'b0, 32'd0,          4'b0110}  // R8 zero
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [11:0] im, input logic ui,
                       input logic ci, input logic sf, input logic pc);
    valid = v; opSel = op; opA = a; opB = b; imm12 = im;
    useImm = ui; carryIn = ci; setFlags = sf; aIsPc = pc;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    rst = 1'b1;
    valid = 1'b0; opSel = 3'd0; opA = '0; opB = '0; imm12 = '0;
    useImm = 1'b0; carryIn = 1'b0; setFlags = 1'b0; aIsPc = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R11 reset state
    check("R11 reset result", {32'd0, result}, 64'd0);
    check("R11 reset flags", {59'd0, flagN, flagZ, flagC, flagV, flagWe}, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].imm,
            VECS[i].ui, VECS[i].ci, 1'b1, VECS[i].pc);
      check($sformatf("R1-5 vec%0d result (R1 R2 R3 R4 R5 R6 R7)", i), {32'd0, result},
            {32'd0, VECS[i].expRes});
      check($sformatf("R8 vec%0d nzcv", i), {60'd0, flagN, flagZ, flagC, flagV},
            {60'd0, VECS[i].expNzcv});
      check($sformatf("R9 vec%0d flagWe", i), {63'd0, flagWe}, 64'd1);
    end

    // last vector left flags 0110. R9: update without setFlags keeps flags
    drive(1'b1, 3'd0, 32'h7FFFFFFF, 32'd1, 12'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9 result updates without setFlags", {32'd0, result}, {32'd0, 32'h80000000});
    check("R9 flags hold", {60'd0, flagN, flagZ, flagC, flagV}, {60'd0, 4'b0110});
    check("R9 flagWe low", {63'd0, flagWe}, 64'd0);

    // R10 valid low: nothing changes
    drive(1'b0, 3'd0, 32'd1, 32'd1, 12'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R10 idle result hold", {32'd0, result}, {32'd0, 32'h80000000});
    check("R10 idle flags hold", {59'd0, flagN, flagZ, flagC, flagV, flagWe}, {59'd0, 5'b01100});

    // R10 unused op codes
    for (int op = 5; op < 8; op++) begin
      drive(1'b1, 3'(op), 32'd9, 32'd9, 12'd0, 1'b0, 1'b1, 1'b1, 1'b0);
      check($sformatf("R10 op%0d result hold", op), {32'd0, result}, {32'd0, 32'h80000000});
      check($sformatf("R10 op%0d flags hold", op),
            {59'd0, flagN, flagZ, flagC, flagV, flagWe}, {59'd0, 5'b01100});
    end

    // R6 immediate offered to reverse subtract is ignored
    drive(1'b1, 3'd4, 32'd1, 32'd3, 12'hABC, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R6 RSB ignores imm", {32'd0, result}, {32'd0, 32'd2});

    // R11 reset clears after activity
    drive(1'b1, 3'd0, 32'hFFFFFFFF, 32'd1, 12'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R8 carry set before reset", {63'd0, flagC}, 64'd1);
    rst = 1'b1;
    drive(1'b1, 3'd0, 32'd5, 32'd5, 12'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R11 reset clears", {27'd0, result, flagN, flagZ, flagC, flagV, flagWe}, 64'd0);
    rst = 1'b0;
    valid = 1'b0;
    @(negedge clk);
    finishRun();
  end

endmodule